// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Unit

This block sits between an instruction queue and two asymmetric execution pipes, called u and v. Each cycle it looks at the two oldest decoded entries of the queue. The older entry is in slot "old" and the younger is in slot "yng". The block decides whether both may start together or whether only the older one may start. The older instruction always goes to u. The younger one can only go to v, and only when it is paired with the older one.

The decision uses the operation class of each entry, its destination and source registers, and a small resource tag. The number of queue entries consumed is presented combinationally in the same cycle, so the queue can pop them at the coming clock edge. The issue strobes and the instruction payloads for the two pipes are registered at that same edge and appear in the following cycle.

A stall input or a flush input in a cycle suppresses all consumption and all issue for that cycle.

Instruction word layout, from the MSB down:
- class: 3 bits
- dst: 5 bits
- srcA: 5 bits
- srcB: 5 bits
- tag: 2 bits

This gives 20 bits in total. Class codes:
- 0 ALU
- 1 shift
- 2 multiply
- 3 divide
- 4 branch
- 5 load/store
- 6 floating point

Top module: `dual_pair_issue`

## Requirements
- R1: When both slots are valid and no restriction applies, `consumed` is 2 in that cycle; in the next cycle `uIssue` and `vIssue` are both 1, `uInstr` equals the older word and `vInstr` equals the younger word.
- R2: The younger entry may pair only when its class is 0, 1, 5 or 4 (branch); a younger class of 2, 3 or 6 gives a single issue (`consumed` 1, only `uIssue` next cycle).
- R3: An older entry of class 4 (branch) never pairs; it issues alone on u.
- R4: A class 6 (floating point) entry in either slot prevents pairing; an older floating-point entry still issues alone on u.
- R5: If the younger srcA or srcB equals the older dst and that index is nonzero, the result is a single issue; a source index of 0 carries no dependency.
- R6: If both tags are equal and nonzero the result is a single issue; tag 0 means no resource and never conflicts.
- R7: A single issue drives `consumed` 1, and in the next cycle `uIssue` 1 carrying the older word with `vIssue` 0; an invalid younger slot simply gives a single issue.
- R8: Issue is in order: with the older slot invalid, `consumed` is 0 and no strobe follows, whatever the younger slot holds.
- R9: With `stall` high in a cycle, `consumed` is 0 in that cycle and both strobes are 0 in the next.
- R10: With `flush` high in a cycle, `consumed` is 0 in that cycle and both strobes are 0 in the next; a decision issued earlier is not repeated.
- R11: After reset both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Downstream stall, blocks issue this cycle |
| flush | input | 1 | Drops both candidates this cycle |
| oldValid | input | 1 | Older slot holds an instruction |
| oldInstr | input | 20 | Older instruction word |
| yngValid | input | 1 | Younger slot holds an instruction |
| yngInstr | input | 20 | Younger instruction word |
| uIssue | output | 1 | Registered start strobe for pipe u |
| uInstr | output | 20 | Registered payload for pipe u |
| vIssue | output | 1 | Registered start strobe for pipe v |
| vInstr | output | 20 | Registered payload for pipe v |
| consumed | output | 2 | Entries taken from the queue this cycle (0, 1, 2) |

## Verification
`consumed` is a same-cycle function of the inputs. The bench therefore drives each scenario just after a falling edge and reads `consumed` one nanosecond later, before the next rising edge. The strobes and payloads are due one rising edge later, so they are read one nanosecond after that edge. At that point they reflect only the scenario just driven. Each directed scenario compares both time points against values worked out from the pairing rules.

// File: rtl/dual_pair_pkg.sv
package dual_pair_pkg;
  localparam int CLASS_W = 3;
  localparam int REG_W   = 5;
  localparam int TAG_W   = 2;
  localparam int INSTR_W = CLASS_W + 3 * REG_W + TAG_W;

  typedef enum logic [CLASS_W-1:0] {
    OP_ALU   = 3'd0,
    OP_SHIFT = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_BRA   = 3'd4,
    OP_MEM   = 3'd5,
    OP_FP    = 3'd6,
    OP_RSVD  = 3'd7
  } opc_e;

  typedef struct packed {
    opc_e             opClass;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [TAG_W-1:0] resTag;
  } instr_t;

  typedef struct packed {
    logic       issueU;
    logic       issueV;
    logic [1:0] take;
  } pair_ctrl_t;
endpackage

// File: rtl/dual_pair_ctrl.sv
module dual_pair_ctrl
  import dual_pair_pkg::*;
(
  input  logic       stall,
  input  logic       flush,
  input  logic       oldValid,
  input  instr_t     oldIn,
  input  logic       yngValid,
  input  instr_t     yngIn,
  output pair_ctrl_t ctrl
);
  logic vClassOk;
  logic rawHit;
  logic resHit;
  logic fpAny;
  logic canPair;
  logic go;
  logic unusedFields;

  assign unusedFields = ^{yngIn.dst, oldIn.srcA, oldIn.srcB};

  always_comb begin
    vClassOk = (yngIn.opClass == OP_ALU) || (yngIn.opClass == OP_SHIFT) ||
               (yngIn.opClass == OP_MEM) || (yngIn.opClass == OP_BRA);
    rawHit   = ((yngIn.srcA != '0) && (yngIn.srcA == oldIn.dst)) ||
               ((yngIn.srcB != '0) && (yngIn.srcB == oldIn.dst));
    resHit   = (oldIn.resTag != '0) && (oldIn.resTag == yngIn.resTag);
    fpAny    = (oldIn.opClass == OP_FP) || (yngIn.opClass == OP_FP);
    canPair  = yngValid && vClassOk && !fpAny && (oldIn.opClass != OP_BRA) &&
               !rawHit && !resHit;
    go       = oldValid && !stall && !flush;

    ctrl.issueU = go;
    ctrl.issueV = go && canPair;
    ctrl.take   = !go ? 2'd0 : (canPair ? 2'd2 : 2'd1);
  end
endmodule

// File: rtl/dual_pair_dp.sv
module dual_pair_dp
  import dual_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pair_ctrl_t ctrl,
  input  instr_t     oldIn,
  input  instr_t     yngIn,
  output logic       uIssue,
  output instr_t     uInstr,
  output logic       vIssue,
  output instr_t     vInstr,
  output logic [1:0] consumed
);
  assign consumed = ctrl.take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uIssue <= 1'b0;
      vIssue <= 1'b0;
      uInstr <= '0;
      vInstr <= '0;
    end else begin
      uIssue <= ctrl.issueU;
      vIssue <= ctrl.issueV;
      if (ctrl.issueU) uInstr <= oldIn;
      if (ctrl.issueV) vInstr <= yngIn;
    end
  end
endmodule

// File: rtl/dual_pair_issue.sv
module dual_pair_issue
  import dual_pair_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stall,
  input  logic               flush,
  input  logic               oldValid,
  input  logic [INSTR_W-1:0] oldInstr,
  input  logic               yngValid,
  input  logic [INSTR_W-1:0] yngInstr,
  output logic               uIssue,
  output logic [INSTR_W-1:0] uInstr,
  output logic               vIssue,
  output logic [INSTR_W-1:0] vInstr,
  output logic [1:0]         consumed
);
  instr_t     oldW;
  instr_t     yngW;
  instr_t     uW;
  instr_t     vW;
  pair_ctrl_t ctrl;

  assign oldW   = instr_t'(oldInstr);
  assign yngW   = instr_t'(yngInstr);
  assign uInstr = uW;
  assign vInstr = vW;

  dual_pair_ctrl u_ctrl (
    .stall    (stall),
    .flush    (flush),
    .oldValid (oldValid),
    .oldIn    (oldW),
    .yngValid (yngValid),
    .yngIn    (yngW),
    .ctrl     (ctrl)
  );

  dual_pair_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .oldIn    (oldW),
    .yngIn    (yngW),
    .uIssue   (uIssue),
    .uInstr   (uW),
    .vIssue   (vIssue),
    .vInstr   (vW),
    .consumed (consumed)
  );
endmodule

// File: rtl/dual_pair_issue_chk.sv
module dual_pair_issue_chk
  import dual_pair_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               stall,
  input logic               flush,
  input logic               oldValid,
  input logic [INSTR_W-1:0] oldInstr,
  input logic               yngValid,
  input logic [INSTR_W-1:0] yngInstr,
  input logic               uIssue,
  input logic [INSTR_W-1:0] uInstr,
  input logic               vIssue,
  input logic [INSTR_W-1:0] vInstr,
  input logic [1:0]         consumed
);
  instr_t uW;
  instr_t vW;
  instr_t oW;
  instr_t yW;
  assign uW = instr_t'(uInstr);
  assign vW = instr_t'(vInstr);
  assign oW = instr_t'(oldInstr);
  assign yW = instr_t'(yngInstr);

  AST_TAKE_TWO: assert property (@(posedge clk) disable iff (!rstN)
    consumed == 2'd2 |=> uIssue && vIssue);  // R1
  AST_V_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    vIssue |-> (vW.opClass == OP_ALU || vW.opClass == OP_SHIFT ||
                vW.opClass == OP_MEM || vW.opClass == OP_BRA));  // R2
  AST_NO_OLD_BRANCH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    vIssue |-> uW.opClass != OP_BRA);  // R3
  AST_NO_FP_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    vIssue |-> uW.opClass != OP_FP);  // R4
  AST_RAW_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (oldValid && yngValid && yW.srcA != '0 && yW.srcA == oW.dst) |-> consumed != 2'd2);  // R5
  AST_RES_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (oldValid && yngValid && oW.resTag != '0 && oW.resTag == yW.resTag) |-> consumed != 2'd2);  // R6
  AST_TAKE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    consumed == 2'd1 |=> uIssue && !vIssue);  // R7
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !oldValid |-> consumed == 2'd0);  // R8
  AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (!rstN)
    vIssue |-> uIssue);  // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !uIssue && !vIssue);  // R9
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !uIssue && !vIssue);  // R10
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (stall || flush) |-> consumed == 2'd0);  // R9
endmodule

bind dual_pair_issue dual_pair_issue_chk u_chk (.*);

// File: tb/sim_dual_pair_issue.sv
`timescale 1ns/1ps
module sim_dual_pair_issue;
  import dual_pair_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               stall = 1'b0;
  logic               flush = 1'b0;
  logic               oldValid = 1'b0;
  logic [INSTR_W-1:0] oldInstr = '0;
  logic               yngValid = 1'b0;
  logic [INSTR_W-1:0] yngInstr = '0;
  logic               uIssue;
  logic [INSTR_W-1:0] uInstr;
  logic               vIssue;
  logic [INSTR_W-1:0] vInstr;
  logic [1:0]         consumed;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  dual_pair_issue u0 (
    .clk(clk), .rstN(rstN), .stall(stall), .flush(flush),
    .oldValid(oldValid), .oldInstr(oldInstr),
    .yngValid(yngValid), .yngInstr(yngInstr),
    .uIssue(uIssue), .uInstr(uInstr), .vIssue(vIssue), .vInstr(vInstr),
    .consumed(consumed)
  );

  function automatic logic [INSTR_W-1:0] mk(input int cls, input int d,
                                            input int a, input int b, input int t);
    return {cls[2:0], d[4:0], a[4:0], b[4:0], t[1:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, check same-cycle count and next-cycle strobes/payloads
  task automatic step(input string req, input logic ov, input logic [INSTR_W-1:0] oi,
                      input logic yv, input logic [INSTR_W-1:0] yi,
                      input logic st, input logic fl, input int expTake);
    @(negedge clk);
    oldValid = ov; oldInstr = oi; yngValid = yv; yngInstr = yi;
    stall = st; flush = fl;
    #1;
    chk(req, 32'(consumed), 32'(expTake));
    @(posedge clk);
    #1;
    chk(req, 32'(uIssue), 32'(expTake > 0));
    chk(req, 32'(vIssue), 32'(expTake == 2));
    if (expTake > 0) chk(req, 32'(uInstr), 32'(oi));
    if (expTake == 2) chk(req, 32'(vInstr), 32'(yi));
  endtask

  task automatic t_reset();
    #1;
    chk("R11", 32'(uIssue), 0);
    chk("R11", 32'(vIssue), 0);
  endtask

  task automatic t_pair();
    step("R1", 1, mk(2, 3, 1, 2, 1), 1, mk(0, 4, 5, 6, 2), 0, 0, 2);
    step("R1", 1, mk(0, 7, 0, 0, 0), 1, mk(5, 8, 9, 0, 0), 0, 0, 2);
  endtask

  task automatic t_vclass();
    step("R2", 1, mk(0, 3, 1, 2, 0), 1, mk(2, 4, 5, 6, 0), 0, 0, 1);
    step("R2", 1, mk(0, 3, 1, 2, 0), 1, mk(3, 4, 5, 6, 0), 0, 0, 1);
    step("R2", 1, mk(0, 3, 1, 2, 0), 1, mk(1, 4, 5, 6, 0), 0, 0, 2);
    step("R2", 1, mk(0, 3, 1, 2, 0), 1, mk(4, 0, 5, 6, 0), 0, 0, 2);
  endtask

  task automatic t_branch();
    step("R3", 1, mk(4, 0, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 0, 1);
  endtask

  task automatic t_fp();
    step("R4", 1, mk(6, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 0, 1);
    step("R4", 1, mk(0, 3, 1, 2, 0), 1, mk(6, 4, 5, 6, 0), 0, 0, 1);
  endtask

  task automatic t_raw();
    step("R5", 1, mk(0, 9, 1, 2, 0), 1, mk(0, 4, 9, 6, 0), 0, 0, 1);
    step("R5", 1, mk(0, 9, 1, 2, 0), 1, mk(0, 4, 5, 9, 0), 0, 0, 1);
    step("R5", 1, mk(0, 0, 1, 2, 0), 1, mk(0, 4, 0, 0, 0), 0, 0, 2);
  endtask

  task automatic t_res();
    step("R6", 1, mk(0, 3, 1, 2, 2), 1, mk(0, 4, 5, 6, 2), 0, 0, 1);
    step("R6", 1, mk(0, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 0, 2);
  endtask

  task automatic t_single();
    step("R7", 1, mk(5, 3, 1, 2, 1), 0, mk(0, 4, 5, 6, 0), 0, 0, 1);
  endtask

  task automatic t_order();
    step("R8", 0, mk(0, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 0, 0);
  endtask

  task automatic t_stall();
    step("R9", 1, mk(0, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 1, 0, 0);
    step("R9", 1, mk(0, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 0, 2);
  endtask

  task automatic t_flush();
    step("R10", 1, mk(0, 3, 1, 2, 0), 1, mk(0, 4, 5, 6, 0), 0, 1, 0);
    step("R10", 0, mk(0, 0, 0, 0, 0), 0, mk(0, 0, 0, 0, 0), 0, 0, 0);
  endtask

  initial begin
    #20000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_pair();
    t_vclass();
    t_branch();
    t_fp();
    t_raw();
    t_res();
    t_single();
    t_order();
    t_stall();
    t_flush();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule